// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a relative alarm timer. Software writes a count of seconds into a load register. While counting is enabled, each pulse on the 1 Hz tick input takes one off the remaining value. The tick that brings the value from one to zero sets a sticky pending flag. The pending flag drives an interrupt output through an interrupt-enable bit, and a wakeup output through a separate wakeup-enable bit. Software acknowledges the alarm by writing 1 to the pending bit.

A second, weekly alarm exists only as three registers: run, interrupt-enable and pending. Nothing in the block matches against a time of day, so its pending bit never sets, and it never drives either output. To reload the countdown, software turns counting off, writes 0 to the load register, writes the new count and turns counting back on. The register bus is a simple write strobe with an address, and the read data is combinational from the address.

Top module: `cdalarm_top`

## Requirements
- R1: After reset every register reads 0, and `irq_o` and `wake_o` are low.
- R2: A bus write to the load register (0x00) copies the written value into the remaining count at that clock edge. The remaining count reads at 0x04, and the load register reads back the last value written.
- R3: While the run bit (bit 0 of 0x08) is 1 and the remaining count is nonzero, each clock edge that samples `tick_1hz` high takes one off the count. Edges without a tick leave it unchanged.
- R4: While the run bit is 0, ticks leave the remaining count unchanged.
- R5: The tick that takes the count from 1 to 0 sets the pending bit (bit 0 of 0x10). A count of 0 stays at 0 under further ticks.
- R6: Loading 0, with or without ticks following, never sets the pending bit.
- R7: Writing 1 to bit 0 of 0x10 clears the pending bit. Writing 0 there has no effect.
- R8: `irq_o` is high exactly when the pending bit and the interrupt-enable bit (bit 0 of 0x0C) are both 1.
- R9: `wake_o` is high exactly when the pending bit and the wakeup-enable bit (bit 0 of 0x14) are both 1.
- R10: When a load write and a counting tick fall on the same edge, the loaded value is taken and no decrement applies.
- R11: The week alarm's run (0x20) and interrupt-enable (0x24) bits store bit 0 of a write, and their upper bits read 0. Its pending bit (bit 0 of 0x28) is write-1-to-clear, never sets, and never affects `irq_o` or `wake_o`.
- R12: A read from an address that is not mapped returns 0.
- R13: When the zero-reaching tick and a write-1-to-clear of pending fall on the same edge, pending ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1hz | input | 1 | One-clock pulse per second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Alarm interrupt request |
| wake_o | output | 1 | Alarm wakeup request |

## Verification
A wrong remaining count can be seen at the 0x04 read port in the cycle after the offending edge. A missed or extra decrement therefore shows up at the next read, and it also moves the edge at which pending sets by whole ticks. A pending flag that sets falsely or fails to clear reaches `irq_o` and `wake_o` combinationally in that same cycle once the enables are on. A load that loses out to a tick leaves the count one below the written value, and a read shows that at once.

// File: rtl/cdalarm_pkg.sv
package cdalarm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_LOAD    = 8'h00;
  localparam logic [ADDR_W-1:0] A_LEFT    = 8'h04;
  localparam logic [ADDR_W-1:0] A_RUN     = 8'h08;
  localparam logic [ADDR_W-1:0] A_IEN     = 8'h0C;
  localparam logic [ADDR_W-1:0] A_PEND    = 8'h10;
  localparam logic [ADDR_W-1:0] A_WAKE    = 8'h14;
  localparam logic [ADDR_W-1:0] A_WK_RUN  = 8'h20;
  localparam logic [ADDR_W-1:0] A_WK_IEN  = 8'h24;
  localparam logic [ADDR_W-1:0] A_WK_PEND = 8'h28;

  typedef struct packed {
    logic run;
    logic irq_en;
    logic wake_en;
    logic wk_run;
    logic wk_irq_en;
  } ctl_t;
endpackage

// File: rtl/cdalarm_rstsync.sv
module cdalarm_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cdalarm_cnt.sv
module cdalarm_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] left_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] left_d;
  logic             step;
  logic             upd;

  always_comb begin
    step   = run_i && tick_i && (left_q != '0) && !load_i;
    upd    = load_i || step;
    left_d = left_q;
    if (load_i)    left_d = load_val_i;
    else if (step) left_d = left_q - ONE;
    hit_o  = step && (left_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   left_q <= '0;
    else if (upd) left_q <= left_d;
  end

  assign left_o = left_q;
endmodule

// File: rtl/cdalarm_sticky.sv
module cdalarm_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;
  logic d;
  logic en;

  always_comb begin
    en = set_i || clr_i;
    d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/cdalarm_regs.sv
module cdalarm_regs
  import cdalarm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  left_i,
  input  logic              pend_i,
  input  logic              wk_pend_i,
  output ctl_t              ctl_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              pend_clr_o,
  output logic              wk_pend_clr_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [CNT_W-1:0] load_q;
  ctl_t             ctl_q;
  ctl_t             ctl_d;
  logic             ctl_en;

  always_comb begin
    load_o        = wr_i && (addr_i == A_LOAD);
    load_val_o    = wdata_i[CNT_W-1:0];
    pend_clr_o    = wr_i && (addr_i == A_PEND) && wdata_i[0];
    wk_pend_clr_o = wr_i && (addr_i == A_WK_PEND) && wdata_i[0];
    ctl_d  = ctl_q;
    ctl_en = 1'b0;
    if (wr_i) begin
      ctl_en = 1'b1;
      case (addr_i)
        A_RUN:    ctl_d.run       = wdata_i[0];
        A_IEN:    ctl_d.irq_en    = wdata_i[0];
        A_WAKE:   ctl_d.wake_en   = wdata_i[0];
        A_WK_RUN: ctl_d.wk_run    = wdata_i[0];
        A_WK_IEN: ctl_d.wk_irq_en = wdata_i[0];
        default:  ctl_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      load_q <= '0;
    else if (load_o) load_q <= load_val_o;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        rdata_o = '0;
        case (addr_i)
          A_LOAD:    rdata_o = {{PAD_W{1'b0}}, load_q};
          A_LEFT:    rdata_o = {{PAD_W{1'b0}}, left_i};
          A_RUN:     rdata_o[0] = ctl_q.run;
          A_IEN:     rdata_o[0] = ctl_q.irq_en;
          A_PEND:    rdata_o[0] = pend_i;
          A_WAKE:    rdata_o[0] = ctl_q.wake_en;
          A_WK_RUN:  rdata_o[0] = ctl_q.wk_run;
          A_WK_IEN:  rdata_o[0] = ctl_q.wk_irq_en;
          A_WK_PEND: rdata_o[0] = wk_pend_i;
          default:   rdata_o = '0;
        endcase
      end
    end else begin : g_full
      always_comb begin
        rdata_o = '0;
        case (addr_i)
          A_LOAD:    rdata_o = load_q;
          A_LEFT:    rdata_o = left_i;
          A_RUN:     rdata_o[0] = ctl_q.run;
          A_IEN:     rdata_o[0] = ctl_q.irq_en;
          A_PEND:    rdata_o[0] = pend_i;
          A_WAKE:    rdata_o[0] = ctl_q.wake_en;
          A_WK_RUN:  rdata_o[0] = ctl_q.wk_run;
          A_WK_IEN:  rdata_o[0] = ctl_q.wk_irq_en;
          A_WK_PEND: rdata_o[0] = wk_pend_i;
          default:   rdata_o = '0;
        endcase
      end
    end
  endgenerate

  assign ctl_o = ctl_q;
endmodule

// File: rtl/cdalarm_top.sv
module cdalarm_top
  import cdalarm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wake_o
);
  logic             rst_q_n;
  ctl_t             ctl;
  logic             load_stb;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] left;
  logic             hit;
  logic             pend_clr;
  logic             wk_pend_clr;
  logic             pend_q;
  logic             wk_pend_q;

  cdalarm_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  cdalarm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .left_i(left),
    .pend_i(pend_q), .wk_pend_i(wk_pend_q), .ctl_o(ctl),
    .load_o(load_stb), .load_val_o(load_val),
    .pend_clr_o(pend_clr), .wk_pend_clr_o(wk_pend_clr)
  );

  cdalarm_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_q_n), .load_i(load_stb), .load_val_i(load_val),
    .run_i(ctl.run), .tick_i(tick_1hz), .left_o(left), .hit_o(hit)
  );

  cdalarm_sticky u_pend (
    .clk(clk), .rst_n(rst_q_n), .set_i(hit), .clr_i(pend_clr), .q_o(pend_q)
  );

  cdalarm_sticky u_wk_pend (
    .clk(clk), .rst_n(rst_q_n), .set_i(1'b0), .clr_i(wk_pend_clr),
    .q_o(wk_pend_q)
  );

  always_comb begin
    irq_o  = pend_q && ctl.irq_en;
    wake_o = pend_q && ctl.wake_en;
  end
endmodule

// File: rtl/cdalarm_chk.sv
module cdalarm_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             ld,
  input logic [CNT_W-1:0] ld_val,
  input logic [CNT_W-1:0] left,
  input logic             hit,
  input logic             pend,
  input logic             ien,
  input logic             wen,
  input logic             irq,
  input logic             wake
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> left == $past(ld_val)); // R2
  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && run && tick && left != '0) |=> left == $past(left) - 1'b1); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !run) |=> $stable(left)); // R4
  AST_HIT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend); // R5
  AST_ZERO_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && left == '0) |=> left == '0); // R5
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pend) && ien) |-> irq); // R8
  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |-> !wake); // R9
endmodule

bind cdalarm_top cdalarm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .run(ctl.run), .tick(tick_1hz),
  .ld(load_stb), .ld_val(load_val), .left(left), .hit(hit),
  .pend(pend_q), .ien(ctl.irq_en), .wen(ctl.wake_en),
  .irq(irq_o), .wake(wake_o)
);

// File: tb/sim_cdalarm_top.sv
module sim_cdalarm_top;
  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        wr;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic        wake;
  int total;
  int bad;

  cdalarm_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_o(irq), .wake_o(wake)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 'h30; a += 4) begin
      rd_reg(a[7:0], v); chk("R1 reg", v, 0);
    end
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 wake", {31'd0, wake}, 0);
  endtask

  task automatic t_load;
    logic [31:0] v;
    wr_reg(8'h00, 32'd5);
    rd_reg(8'h04, v); chk("R2 left", v, 5);
    rd_reg(8'h00, v); chk("R2 loadback", v, 5);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    pulse(3);
    rd_reg(8'h04, v); chk("R4 stopped", v, 5);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr_reg(8'h08, 1);
    pulse(1);
    rd_reg(8'h04, v); chk("R3 one tick", v, 4);
    repeat (5) @(negedge clk);
    rd_reg(8'h04, v); chk("R3 no tick", v, 4);
    pulse(3);
    rd_reg(8'h10, v); chk("R5 not yet", v, 0);
    pulse(1);
    rd_reg(8'h04, v); chk("R5 zero", v, 0);
    rd_reg(8'h10, v); chk("R5 pend", v, 1);
    chk("R8 irq off", {31'd0, irq}, 0);
    pulse(2);
    rd_reg(8'h04, v); chk("R5 stays zero", v, 0);
  endtask

  task automatic t_outputs;
    logic [31:0] v;
    wr_reg(8'h0C, 1);
    #1 chk("R8 irq on", {31'd0, irq}, 1);
    chk("R9 wake off", {31'd0, wake}, 0);
    wr_reg(8'h14, 1);
    #1 chk("R9 wake on", {31'd0, wake}, 1);
    wr_reg(8'h10, 0);
    rd_reg(8'h10, v); chk("R7 write0", v, 1);
    wr_reg(8'h10, 1);
    rd_reg(8'h10, v); chk("R7 clear", v, 0);
    chk("R8 irq clr", {31'd0, irq}, 0);
    chk("R9 wake clr", {31'd0, wake}, 0);
  endtask

  task automatic t_zero_load;
    logic [31:0] v;
    wr_reg(8'h08, 0);
    wr_reg(8'h00, 0);
    wr_reg(8'h08, 1);
    pulse(3);
    rd_reg(8'h10, v); chk("R6 no pend", v, 0);
    chk("R8 irq quiet", {31'd0, irq}, 0);
  endtask

  task automatic t_race;
    logic [31:0] v;
    wr_reg(8'h00, 3);
    @(negedge clk);
    wr = 1'b1; addr = 8'h00; wdata = 32'd10; tick = 1'b1;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
    rd_reg(8'h04, v); chk("R10 load wins", v, 10);
  endtask

  task automatic t_setclr;
    logic [31:0] v;
    wr_reg(8'h00, 1);
    @(negedge clk);
    wr = 1'b1; addr = 8'h10; wdata = 32'd1; tick = 1'b1;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
    rd_reg(8'h10, v); chk("R13 set wins", v, 1);
    wr_reg(8'h10, 1);
  endtask

  task automatic t_week;
    logic [31:0] v;
    wr_reg(8'h20, 32'hFFFF_FFFF);
    rd_reg(8'h20, v); chk("R11 wk run", v, 1);
    wr_reg(8'h24, 32'hFFFF_FFFF);
    rd_reg(8'h24, v); chk("R11 wk ien", v, 1);
    wr_reg(8'h28, 1);
    pulse(2);
    rd_reg(8'h28, v); chk("R11 wk pend", v, 0);
    chk("R11 irq", {31'd0, irq}, 0);
    chk("R11 wake", {31'd0, wake}, 0);
    rd_reg(8'h3C, v); chk("R12 unmapped", v, 0);
    rd_reg(8'h18, v); chk("R12 gap", v, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; tick = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load();
    t_hold();
    t_count();
    t_outputs();
    t_zero_load();
    t_race();
    t_setclr();
    t_week();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule